// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Channel

One channel that hangs off a shared 16-bit counter, which is built and clocked outside this block. A 7-bit mode word sets up its function. The channel can latch the counter value when an external input changes. It can flag the cycle in which the counter reaches a programmed value, and it can toggle an output pin at that point. It can also drive the pin as a pulse-width-modulated signal.

Every capture and every flagged match sets a sticky event flag. Only software clears that flag. The flag can raise an interrupt when the mode word allows it. Several copies of the block sit side by side on one counter, one copy per pin.

Top module: `capcmp_channel`

## Requirements
- R1: After reset the mode word, the compare register, the PWM duty latch, the toggle output and the event flag are all zero, so `pin_out` and `irq` are low.
- R2: `mode_wr` loads `mode_wdata` into the mode word, which reads back on `mode_rd`. The bit meanings are: bit 0 interrupt enable, bit 1 PWM, bit 2 toggle on match, bit 3 flag on match, bit 4 falling-edge capture, bit 5 rising-edge capture, bit 6 comparator enable.
- R3: `pin_in` passes through a two-flop synchronizer before edge detection. A level change driven just after clock edge E0 is captured at edge E3, the third edge after it.
- R4: A capture loads the counter value present at the capturing edge into the compare register. A rising edge captures only when bit 5 is set, and a falling edge captures only when bit 4 is set. With both bits set, either edge captures. With neither bit set, an edge leaves the register and the flag unchanged.
- R5: A capture sets the event flag.
- R6: A match is bit 6 set, `tb_tick` high, and `tb_count` equal to the compare register, all in the same cycle. A match sets the flag only when bit 3 is set. Without `tb_tick`, or without bit 6, equality does nothing.
- R7: Outside PWM mode, a match with bit 2 set inverts `pin_out` at the next edge.
- R8: The flag stays set until `flag_clr`. If a hardware set and `flag_clr` fall in the same cycle, the flag stays set.
- R9: If a capture and `reg_wr` fall in the same cycle, the capture wins and the written value is lost.
- R10: PWM mode needs both bit 1 and bit 6. In PWM mode, `pin_out` is low while `tb_count[7:0]` is below the duty latch and high otherwise. The duty latch takes the compare register's bits 15:8 only on a `tb_tick` with `tb_count[7:0]` equal to 8'hFF, so a register write in mid-period has no effect until that point.
- R11: `irq` is high exactly when the flag is set and mode bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_count | input | 16 | Shared counter value |
| tb_tick | input | 1 | Counter increment strobe |
| mode_wr | input | 1 | Mode word write strobe |
| mode_wdata | input | 7 | Mode word write data |
| reg_wr | input | 1 | Compare register write strobe |
| reg_wdata | input | 16 | Compare register write data |
| flag_clr | input | 1 | Software clear of the event flag |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Toggle or PWM output |
| mode_rd | output | 7 | Mode word readback |
| reg_rd | output | 16 | Compare register readback |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a capture and a software write to the compare register. The bench counts synchronizer stages to put `reg_wr` in the exact cycle in which the detected edge becomes visible, then expects the captured counter value rather than the written data. The second pair is a hardware flag set and a software clear. The bench raises `flag_clr` together with a flagged match and expects the flag to remain set afterwards.

// File: rtl/capcmp_channel.sv
module capcmp_channel #(
  parameter int CW = 16,
  parameter int MW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tb_count,
  input  logic          tb_tick,
  input  logic          mode_wr,
  input  logic [MW-1:0] mode_wdata,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_wdata,
  input  logic          flag_clr,
  input  logic          pin_in,
  output logic          pin_out,
  output logic [MW-1:0] mode_rd,
  output logic [CW-1:0] reg_rd,
  output logic          flag,
  output logic          irq
);
  localparam int HW = CW / 2;
  localparam int B_IE = 0, B_PWM = 1, B_TOG = 2, B_MAT = 3, B_CN = 4, B_CP = 5, B_CMP = 6;

  logic [MW-1:0] mode_q;
  logic [CW-1:0] ccr_q;
  logic [HW-1:0] duty_lo;
  logic [2:0]    sync_q;
  logic          flag_q, tog_q;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire cap_evt = (rise & mode_q[B_CP]) | (fall & mode_q[B_CN]);
  wire match   = mode_q[B_CMP] & tb_tick & (tb_count == ccr_q);
  wire pwm_on  = mode_q[B_CMP] & mode_q[B_PWM];
  wire wrap    = tb_tick & (&tb_count[HW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ccr_q   <= '0;
      duty_lo <= '0;
      sync_q  <= '0;
      flag_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], pin_in};
      if (mode_wr) mode_q <= mode_wdata;
      if (cap_evt)     ccr_q <= tb_count;
      else if (reg_wr) ccr_q <= reg_wdata;
      if (cap_evt | (match & mode_q[B_MAT])) flag_q <= 1'b1;
      else if (flag_clr)                     flag_q <= 1'b0;
      if (match & mode_q[B_TOG] & ~pwm_on) tog_q <= ~tog_q;
      if (wrap) duty_lo <= ccr_q[CW-1:HW];
    end
  end

  assign pin_out = pwm_on ? (tb_count[HW-1:0] >= duty_lo) : tog_q;
  assign mode_rd = mode_q;
  assign reg_rd  = ccr_q;
  assign flag    = flag_q;
  assign irq     = flag_q & mode_q[B_IE];
endmodule

// File: rtl/capcmp_channel_chk.sv
module capcmp_channel_chk #(
  parameter int CW = 16,
  parameter int MW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] tb_count,
  input logic          tb_tick,
  input logic          mode_wr,
  input logic          flag_clr,
  input logic [MW-1:0] mode_q,
  input logic [CW-1:0] ccr_q,
  input logic [CW/2-1:0] duty_lo,
  input logic          cap_evt,
  input logic          flag,
  input logic          pin_out
);
  localparam int HW = CW / 2;
  wire cmp_hit = mode_q[6] && tb_tick && (tb_count == ccr_q);

  AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);                                       // R8
  AST_FLAG_FALL_SW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));                                  // R8
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit && mode_q[3] |=> flag);                                    // R6
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag);                                                 // R5
  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ccr_q == $past(tb_count));                             // R9
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit && mode_q[2] && !mode_q[1] && !mode_wr |=> pin_out != $past(pin_out)); // R7
  AST_DUTY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tb_tick && (&tb_count[HW-1:0])) |=> $stable(duty_lo));           // R10
endmodule

bind capcmp_channel capcmp_channel_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_tick(tb_tick),
  .mode_wr(mode_wr), .flag_clr(flag_clr), .mode_q(mode_q), .ccr_q(ccr_q),
  .duty_lo(duty_lo), .cap_evt(cap_evt), .flag(flag), .pin_out(pin_out)
);

// File: tb/test_capcmp_channel.sv
`timescale 1ns/1ps
module test_capcmp_channel;
  logic clk = 0, rst_n = 0;
  logic [15:0] tb_count = '0, reg_wdata = '0;
  logic tb_tick = 0, mode_wr = 0, reg_wr = 0, flag_clr = 0, pin_in = 0;
  logic [6:0] mode_wdata = '0;
  logic pin_out, flag, irq;
  logic [6:0] mode_rd;
  logic [15:0] reg_rd;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  capcmp_channel i_capcmp_channel (
    .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_tick(tb_tick),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .flag_clr(flag_clr), .pin_in(pin_in), .pin_out(pin_out), .mode_rd(mode_rd),
    .reg_rd(reg_rd), .flag(flag), .irq(irq));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [6:0] m);
    mode_wdata = m; mode_wr = 1; step(); mode_wr = 0;
  endtask
  task automatic set_reg(input logic [15:0] v);
    reg_wdata = v; reg_wr = 1; step(); reg_wr = 0;
  endtask
  task automatic clear_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 mode", {9'd0, mode_rd}, 16'h0);
    chk("R1 reg", reg_rd, 16'h0);
    chk("R1 pin/flag/irq", {13'd0, pin_out, flag, irq}, 16'h0);
    rst_n = 1; step();

    // R2 mode readback over every value
    for (int m = 0; m < 128; m++) begin
      set_mode(m[6:0]);
      chk("R2 readback", {9'd0, mode_rd}, m[15:0]);
    end

    // R3 R4 R5 capture sweep over edge enables and both edge directions
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int dir = 0; dir < 2; dir++) begin
        logic exp_cap;
        set_mode(7'h00);
        pin_in = (dir == 1); repeat (4) step();
        clear_flag();
        set_reg(16'h1111);
        set_mode({1'b0, cfg[1], cfg[0], 4'b0000});
        tb_count = 16'h2000 + 16'(cfg * 2 + dir);
        pin_in = (dir == 0);
        step(); step();
        chk("R3 no capture before third edge", reg_rd, 16'h1111);
        step();
        exp_cap = (dir == 0) ? cfg[1] : cfg[0];
        chk("R4 capture value", reg_rd, exp_cap ? tb_count : 16'h1111);
        chk("R5 capture flag", {15'd0, flag}, {15'd0, exp_cap});
      end
    end

    // R9 capture and write in the same cycle
    set_mode(7'h00); pin_in = 0; repeat (4) step(); clear_flag();
    set_mode(7'h20); tb_count = 16'h3A5C;
    pin_in = 1; step(); step();
    reg_wdata = 16'hDEAD; reg_wr = 1; step(); reg_wr = 0;
    chk("R9 capture wins", reg_rd, 16'h3A5C);

    // R6 R7 R11 match sweep over comparator, flag, toggle and irq bits
    pin_in = 0; set_mode(7'h00); repeat (4) step();
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic ecm, mat, tog, ie, p0;
      ecm = cfg[0]; mat = cfg[1]; tog = cfg[2]; ie = cfg[3];
      set_mode({ecm, 2'b00, mat, tog, 1'b0, ie});
      clear_flag();
      set_reg(16'h4000 + 16'(cfg));
      p0 = pin_out;
      tb_count = 16'h4000 + 16'(cfg); tb_tick = 0; step();
      chk("R6 no match without tick", {14'd0, flag, pin_out}, {14'd0, 1'b0, p0});
      tb_tick = 1; step(); tb_tick = 0;
      chk("R6 match flag", {15'd0, flag}, {15'd0, ecm & mat});
      chk("R7 toggle", {15'd0, pin_out}, {15'd0, p0 ^ (ecm & tog)});
      chk("R11 irq", {15'd0, irq}, {15'd0, ecm & mat & ie});
      tb_count = 16'h4001 + 16'(cfg); tb_tick = 1; step(); tb_tick = 0;
      chk("R6 unequal count no toggle", {15'd0, pin_out}, {15'd0, p0 ^ (ecm & tog)});
    end

    // R8 sticky flag, clear, and set versus clear in one cycle
    set_mode(7'h48); clear_flag(); set_reg(16'h5555);
    tb_count = 16'h5555; tb_tick = 1; step(); tb_tick = 0;
    tb_count = 16'h0000; repeat (3) step();
    chk("R8 sticky", {15'd0, flag}, 16'h1);
    clear_flag();
    chk("R8 cleared", {15'd0, flag}, 16'h0);
    tb_count = 16'h5555; tb_tick = 1; flag_clr = 1; step(); tb_tick = 0; flag_clr = 0;
    chk("R8 set beats clear", {15'd0, flag}, 16'h1);

    // R10 PWM sweep of the low byte for several duties
    for (int d = 0; d < 6; d++) begin
      logic [7:0] duty;
      duty = (d == 0) ? 8'h00 : (d == 1) ? 8'h01 : (d == 2) ? 8'h40 :
             (d == 3) ? 8'h80 : (d == 4) ? 8'hC3 : 8'hFF;
      set_mode(7'h42);
      set_reg({duty, 8'h00});
      tb_count = 16'h00FF; tb_tick = 1; step(); tb_tick = 0;
      for (int c = 0; c < 256; c++) begin
        tb_count = 16'(c); #0.2;
        chk("R10 pwm level", {15'd0, pin_out}, {15'd0, (c >= duty)});
      end
    end
    // R10 mid-period write waits for the wrap
    set_reg(16'h4000); tb_count = 16'h00FF; tb_tick = 1; step(); tb_tick = 0;
    set_reg(16'hC000); tb_count = 16'h0080; #0.2;
    chk("R10 old duty kept", {15'd0, pin_out}, 16'h1);
    tb_count = 16'h01FF; tb_tick = 1; step(); tb_tick = 0;
    tb_count = 16'h0080; #0.2;
    chk("R10 new duty after wrap", {15'd0, pin_out}, 16'h0);
    // R10 PWM needs the comparator bit
    set_mode(7'h02); set_reg(16'h0000); tb_count = 16'h00FF; tb_tick = 1; step(); tb_tick = 0;
    chk("R10 pwm off without bit 6", {15'd0, pin_out}, {15'd0, i_capcmp_channel_pin_hold()});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic pin_prev;
  always @(negedge clk) pin_prev <= (mode_rd[1] & mode_rd[6]) ? pin_prev : pin_out;
  function automatic logic i_capcmp_channel_pin_hold(); return pin_prev; endfunction
endmodule